// File: doc/BRIEF.md
# Synchronous Serial Audio Transmitter

This block is the transmit half of a synchronous serial audio port. Parallel words arrive through a small FIFO write port. At the start of each word slot the block moves the head FIFO word into a shift register. It then drives the word out one bit at a time on a serial data pin. The timing comes from a bit clock that the block generates itself from a tick input. The block also generates its own frame sync.

Static level inputs set the behaviour:
- bit order;
- the bit-clock edge on which data and frame sync change;
- frame sync polarity and length (one bit or one word);
- word length (8, 10, 12 or 16 bits);
- normal (one word per frame) or network (several word slots per frame) operation.

When the enable input is low the block is held in reset and its pins are released through an output-enable. The configuration inputs are levels, so they keep their values across a disable and apply again on re-enable.

Top module: `sat_tx`

## Requirements
- R1: While rst_ni is low, oe_o, sd_o, fs_o, bclk_o and underrun_o are 0 and wr_ready_o is 1.
- R2: While en_i is high, a cycle with bclk_tick_i high inverts bclk_o in the following cycle, and a cycle without it leaves bclk_o unchanged. bclk_o starts low after enable.
- R3: With lsb_first_i = 0, the most significant bit of the configured word length goes out first.
- R4: With lsb_first_i = 1, bit 0 of the word goes out first.
- R5: With fall_launch_i = 0, sd_o and fs_o change only in the cycle in which bclk_o goes high. With fall_launch_i = 1, they change only in the cycle in which bclk_o goes low.
- R6: With fs_low_i = 1, frame sync is active low on fs_o. With fs_low_i = 0, it is active high.
- R7: With fs_bit_i = 1, each frame starts with one lead bit period in which frame sync is active and sd_o is 0. The first data bit follows, and frame sync is inactive from then on.
- R8: With fs_bit_i = 0, frame sync is active for every bit of the first word of the frame and inactive for the later slots. Frames follow each other with no gap.
- R9: wlen_i codes 0, 1, 2 and 3 select words of 8, 10, 12 and 16 bits. Word bits above the selected length are not sent.
- R10: With net_i = 0, each frame carries one word. With net_i = 1, each frame carries SLOTS words, and each slot takes the next FIFO word.
- R11: If the FIFO is empty when a word slot starts, the slot is sent as all zeros and underrun_o goes to 1. underrun_o stays at 1 until the block is disabled.
- R12: One cycle after en_i goes low, oe_o, sd_o, fs_o, bclk_o and underrun_o are 0. The FIFO and the shift state are emptied, so words written before the disable are never sent. Writes are ignored while disabled.
- R13: The FIFO holds DEPTH words. wr_ready_o is 0 while it is full, and a word written while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable; low holds the block in reset |
| lsb_first_i | input | 1 | 1 sends bit 0 first, 0 sends the MSB first |
| fall_launch_i | input | 1 | 1 launches data on the bit-clock falling edge, 0 on the rising edge |
| fs_low_i | input | 1 | 1 makes frame sync active low |
| fs_bit_i | input | 1 | 1 selects a one-bit lead frame sync, 0 a one-word frame sync |
| net_i | input | 1 | 1 selects network mode (SLOTS words per frame) |
| wlen_i | input | 2 | Word length code: 8, 10, 12 or 16 bits |
| wr_valid_i | input | 1 | FIFO write strobe |
| wr_data_i | input | DW | FIFO write data |
| wr_ready_o | output | 1 | FIFO not full |
| bclk_tick_i | input | 1 | Half-period tick for the bit clock |
| bclk_o | output | 1 | Generated bit clock |
| sd_o | output | 1 | Serial data |
| fs_o | output | 1 | Frame sync |
| oe_o | output | 1 | Output enable for bclk_o, sd_o and fs_o |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
The bench targets these corner cases:
- **Word boundary.** The bit counter must wrap at exactly 8, 10, 12 and 16 bits. A wrong wrap sends stray upper bits, or it slips the frame sync of the next frame by a bit.
- **Lead bit versus word-long sync.** In network mode the word-long sync must drop after slot 0. A sequencer that confuses the two modes holds frame sync across every slot, or it sends data during the lead bit.
- **Launch polarity.** Falling-edge launch must move data on the other half-period. A design that ignores it moves data half a bit period early.
- **Underrun.** An empty FIFO must give a zero slot and a sticky flag, not a repeat of the previous word.
- **Flush on disable.** Words written before a disable must never be sent. A design that keeps the FIFO across the disable sends stale audio where an underrun is expected.
- **Full FIFO.** A write to a full FIFO must leave the queue unchanged. A design that accepts it corrupts the sent order.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_DATA
  } seq_st_e;

  // word length code -> bits per word
  function automatic logic [4:0] wlen_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd8;
      2'd1:    return 5'd10;
      2'd2:    return 5'd12;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/sat_fifo.sv
module sat_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r13_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> full_o);

  a_r13_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/sat_bclk.sv
module sat_bclk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic fall_launch_i,
  output logic bclk_o,
  output logic launch_o
);
  logic bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bclk_q <= 1'b0;
    else if (!en_i)  bclk_q <= 1'b0;
    else if (tick_i) bclk_q <= ~bclk_q;
  end

  assign bclk_o = bclk_q;
  // launch when this tick produces the selected edge
  assign launch_o = en_i && tick_i && (bclk_q == fall_launch_i);

  a_r2_bclk_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i) |=> (bclk_o != $past(bclk_o)));

  a_r2_bclk_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(bclk_o));

endmodule

// File: rtl/sat_seq.sv
module sat_seq
  import sat_pkg::*;
#(
  parameter int DW    = 16,  // at least 16
  parameter int SLOTS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          launch_i,
  input  logic          lsb_first_i,
  input  logic          fs_bit_i,
  input  logic          net_i,
  input  logic [1:0]    wlen_i,
  input  logic          fifo_empty_i,
  input  logic [DW-1:0] fifo_data_i,
  output logic          pop_o,
  output logic          sd_o,
  output logic          fs_act_o,
  output logic          underrun_o
);
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int BW = $clog2(DW + 1);

  seq_st_e       st_q;
  logic [BW-1:0] bit_q;
  logic [SW-1:0] slot_q;
  logic [DW-1:0] sh_q;
  logic          sd_q, fs_q, ur_q;

  logic [BW-1:0] wbits;
  logic          last_bit, last_slot, frame_end, from_lead, next_slot, start_word;
  logic [DW-1:0] mask, word_m, word_al;

  always_comb begin
    wbits      = BW'(wlen_bits(wlen_i));
    last_bit   = (bit_q == wbits - BW'(1));
    last_slot  = !net_i || (slot_q == SW'(SLOTS - 1));
    frame_end  = (st_q == ST_IDLE) || ((st_q == ST_DATA) && last_bit && last_slot);
    from_lead  = (st_q == ST_LEAD);
    next_slot  = (st_q == ST_DATA) && last_bit && !last_slot;
    start_word = launch_i && ((frame_end && !fs_bit_i) || from_lead || next_slot);
    mask       = ~({DW{1'b1}} << wbits);
    word_m     = fifo_empty_i ? '0 : (fifo_data_i & mask);
    word_al    = word_m << (BW'(DW) - wbits);
  end

  assign pop_o = start_word && !fifo_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      slot_q <= '0;
      sh_q   <= '0;
      sd_q   <= 1'b0;
      fs_q   <= 1'b0;
      ur_q   <= 1'b0;
    end else if (!en_i) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      slot_q <= '0;
      sh_q   <= '0;
      sd_q   <= 1'b0;
      fs_q   <= 1'b0;
      ur_q   <= 1'b0;
    end else begin
      if (start_word && fifo_empty_i) ur_q <= 1'b1;
      if (launch_i) begin
        if (start_word) begin
          st_q  <= ST_DATA;
          bit_q <= '0;
          if (lsb_first_i) begin
            sd_q <= word_m[0];
            sh_q <= word_m >> 1;
          end else begin
            sd_q <= word_al[DW-1];
            sh_q <= word_al << 1;
          end
          if (frame_end) begin
            slot_q <= '0;
            fs_q   <= 1'b1;
          end else if (from_lead) begin
            slot_q <= '0;
            fs_q   <= 1'b0;
          end else begin
            slot_q <= slot_q + SW'(1);
            fs_q   <= 1'b0;
          end
        end else if (frame_end) begin
          // lead bit of a one-bit frame sync
          st_q <= ST_LEAD;
          fs_q <= 1'b1;
          sd_q <= 1'b0;
        end else begin
          bit_q <= bit_q + BW'(1);
          if (lsb_first_i) begin
            sd_q <= sh_q[0];
            sh_q <= sh_q >> 1;
          end else begin
            sd_q <= sh_q[DW-1];
            sh_q <= sh_q << 1;
          end
        end
      end
    end
  end

  assign sd_o       = sd_q;
  assign fs_act_o   = fs_q;
  assign underrun_o = ur_q;

  a_r7_lead_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && launch_i && st_q == ST_LEAD) |=> !fs_act_o);

  a_r11_underrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ur_q) |=> ur_q);

  a_r5_hold_between_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !launch_i) |=> ($stable(sd_q) && $stable(fs_q)));

endmodule

// File: rtl/sat_tx.sv
module sat_tx #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  parameter int SLOTS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          lsb_first_i,
  input  logic          fall_launch_i,
  input  logic          fs_low_i,
  input  logic          fs_bit_i,
  input  logic          net_i,
  input  logic [1:0]    wlen_i,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_ready_o,
  input  logic          bclk_tick_i,
  output logic          bclk_o,
  output logic          sd_o,
  output logic          fs_o,
  output logic          oe_o,
  output logic          underrun_o
);
  logic          fifo_empty, fifo_full, pop;
  logic [DW-1:0] fifo_data;
  logic          bclk, launch, sd, fs_act, ur;
  logic          oe_q;

  sat_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!en_i),
    .push_i  (wr_valid_i && en_i),
    .data_i  (wr_data_i),
    .pop_i   (pop),
    .data_o  (fifo_data),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  sat_bclk u_bclk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .tick_i        (bclk_tick_i),
    .fall_launch_i (fall_launch_i),
    .bclk_o        (bclk),
    .launch_o      (launch)
  );

  sat_seq #(.DW(DW), .SLOTS(SLOTS)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .launch_i     (launch),
    .lsb_first_i  (lsb_first_i),
    .fs_bit_i     (fs_bit_i),
    .net_i        (net_i),
    .wlen_i       (wlen_i),
    .fifo_empty_i (fifo_empty),
    .fifo_data_i  (fifo_data),
    .pop_o        (pop),
    .sd_o         (sd),
    .fs_act_o     (fs_act),
    .underrun_o   (ur)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= en_i;
  end

  assign oe_o       = oe_q;
  assign bclk_o     = oe_q && bclk;
  assign sd_o       = oe_q && sd;
  assign fs_o       = oe_q && (fs_act ^ fs_low_i);
  assign underrun_o = ur;
  assign wr_ready_o = !fifo_full;

  a_r12_disable_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!oe_o && !underrun_o && !bclk_o && !sd_o));

endmodule

// File: tb/sat_tx_tb.sv
module sat_tx_tb;
  localparam int DW = 16, DEPTH = 4, SLOTS = 4;

  logic clk = 1'b0, rst_ni = 1'b0, en_i = 1'b0;
  logic lsb_first_i = 1'b0, fall_launch_i = 1'b0, fs_low_i = 1'b0, fs_bit_i = 1'b0, net_i = 1'b0;
  logic [1:0] wlen_i = 2'd0;
  logic wr_valid_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic bclk_tick_i = 1'b0;
  logic wr_ready_o, bclk_o, sd_o, fs_o, oe_o, underrun_o;

  always #5 clk = ~clk;

  sat_tx #(.DW(DW), .DEPTH(DEPTH), .SLOTS(SLOTS)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .lsb_first_i(lsb_first_i),
    .fall_launch_i(fall_launch_i), .fs_low_i(fs_low_i), .fs_bit_i(fs_bit_i),
    .net_i(net_i), .wlen_i(wlen_i), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
    .wr_ready_o(wr_ready_o), .bclk_tick_i(bclk_tick_i), .bclk_o(bclk_o),
    .sd_o(sd_o), .fs_o(fs_o), .oe_o(oe_o), .underrun_o(underrun_o)
  );

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  // behavioural reference model
  logic [DW-1:0] q[$];
  int m_bclk, m_ph, m_bit, m_slot, m_fs, m_sd, m_ur, m_oe;
  int unsigned m_word;
  bit m_valid = 0;

  function automatic int wl(logic [1:0] c);
    case (c)
      2'd0: return 8;
      2'd1: return 10;
      2'd2: return 12;
      default: return 16;
    endcase
  endfunction

  function automatic void m_load(int w);
    if (q.size() > 0) m_word = int'(q.pop_front()) & ((1 << w) - 1);
    else begin
      m_word = 0;
      m_ur = 1;
    end
  endfunction

  always @(posedge clk) begin
    m_valid = 1;
    if (!rst_ni || !en_i) begin
      q.delete();
      m_bclk = 0; m_ph = 0; m_bit = 0; m_slot = 0;
      m_fs = 0; m_sd = 0; m_ur = 0; m_oe = 0; m_word = 0;
    end else begin
      bit acc, launch;
      int w, s;
      acc = wr_valid_i && (q.size() < DEPTH);
      w = wl(wlen_i);
      s = net_i ? SLOTS : 1;
      launch = bclk_tick_i && (m_bclk == int'(fall_launch_i));
      if (bclk_tick_i) m_bclk ^= 1;
      if (launch) begin
        if (m_ph == 0 || (m_ph == 2 && m_bit == w - 1 && m_slot == s - 1)) begin
          if (fs_bit_i) begin
            m_ph = 1; m_fs = 1;
          end else begin
            m_ph = 2; m_bit = 0; m_slot = 0; m_fs = 1; m_load(w);
          end
        end else if (m_ph == 1) begin
          m_ph = 2; m_bit = 0; m_slot = 0; m_fs = 0; m_load(w);
        end else if (m_bit < w - 1) begin
          m_bit++;
        end else begin
          m_slot++; m_bit = 0; m_fs = 0; m_load(w);
        end
        m_sd = (m_ph == 2) ? int'((m_word >> (lsb_first_i ? m_bit : w - 1 - m_bit)) & 1) : 0;
      end
      if (acc) q.push_back(wr_data_i);
      m_oe = 1;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (m_valid && !done) begin
      logic [5:0] exp_v, act_v;
      exp_v = {(m_oe != 0) && (m_bclk != 0), (m_oe != 0) && (m_sd != 0),
               (m_oe != 0) && ((m_fs != 0) ^ fs_low_i), m_oe != 0, m_ur != 0,
               q.size() < DEPTH};
      act_v = {bclk_o, sd_o, fs_o, oe_o, underrun_o, wr_ready_o};
      n_cmp++;
      if (act_v !== exp_v) begin
        n_bad++;
        $display("FAIL %s: {bclk,sd,fs,oe,ur,rdy} actual %b expected %b at %0t",
                 cur_req, act_v, exp_v, $time);
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp_v, $time);
    end
  endtask

  int tick_div = 1, tick_cnt = 0, words_left = 0, wcnt = 0;
  bit prev_rdy = 1;

  task automatic cyc();
    @(posedge clk);
    #2;
    if (wr_valid_i && prev_rdy) begin
      words_left--;
      wcnt++;
    end
    prev_rdy   = wr_ready_o;
    wr_valid_i = en_i && (words_left > 0);
    wr_data_i  = DW'(32'hA5C3 ^ (wcnt * 32'h1F3B));
    tick_cnt++;
    if (tick_cnt >= tick_div) begin
      tick_cnt = 0;
      bclk_tick_i = 1'b1;
    end else bclk_tick_i = 1'b0;
  endtask

  task automatic run_case(string req, bit lsb, bit fall, bit fslow, bit fsbit, bit net,
                          logic [1:0] wc, int div, int nw, int ncyc);
    cur_req = req;
    en_i = 1'b0;
    words_left = 0;
    repeat (2) cyc();
    lsb_first_i = lsb; fall_launch_i = fall; fs_low_i = fslow;
    fs_bit_i = fsbit; net_i = net; wlen_i = wc;
    tick_div = div; tick_cnt = 0;
    en_i = 1'b1;
    words_left = nw;
    repeat (ncyc) cyc();
  endtask

  initial begin
    repeat (3) cyc();
    check("R1", {oe_o, sd_o, fs_o, bclk_o, underrun_o, wr_ready_o}, 32'b000001);
    rst_ni = 1'b1;

    run_case("R2 R3 R7 R9", 0, 0, 0, 1, 0, 2'd0, 1, 6, 200);
    run_case("R4 R8 R9",    1, 0, 0, 0, 0, 2'd1, 2, 6, 300);
    run_case("R5 R6 R9",    0, 1, 1, 1, 0, 2'd2, 3, 6, 600);
    run_case("R10 R8 R4",   1, 1, 1, 0, 1, 2'd3, 1, 12, 500);
    run_case("R10 R7 R3",   0, 0, 0, 1, 1, 2'd0, 2, 12, 500);

    run_case("R11", 0, 0, 0, 0, 0, 2'd0, 1, 1, 100);
    check("R11", underrun_o, 1);

    // R12: queue words with the bit clock stopped, then disable
    cur_req = "R12";
    tick_div = 1000000; tick_cnt = 0;
    words_left = 3;
    repeat (8) cyc();
    en_i = 1'b0;
    words_left = 0;
    repeat (2) cyc();
    check("R12", {oe_o, sd_o, fs_o, bclk_o, underrun_o, wr_ready_o}, 32'b000001);
    en_i = 1'b1;
    tick_div = 1; tick_cnt = 0;
    repeat (40) cyc();
    check("R12", underrun_o, 1);  // flushed words never sent

    // R13: overfill with the bit clock stopped
    en_i = 1'b0;
    repeat (2) cyc();
    cur_req = "R13";
    tick_div = 1000000; tick_cnt = 0;
    en_i = 1'b1;
    bclk_tick_i = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++) begin
      wr_valid_i = 1'b1;
      wr_data_i = DW'(32'h3C00 + i * 32'h0111);
      @(posedge clk);
      #2;
    end
    wr_valid_i = 1'b0;
    check("R13", wr_ready_o, 0);
    prev_rdy = wr_ready_o;
    tick_div = 1; tick_cnt = 0;
    repeat (150) cyc();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule